// File: doc/BRIEF.md
# PCI Bus Arbiter with Parking and Broken-Master Detection

This block shares one PCI bus among seven masters: one internal master (agent index 0) and six external masters (agent indices 1 to 6). Each master raises its own request line. The arbiter answers on one grant line per master. A FRAME input tells the arbiter when the granted master has started a transaction. A single 32-bit control register sets the behaviour. It holds an arbitration enable, a priority class per agent, a per-agent parking control, and the settings for broken-master detection. The same register also reports which masters have been found broken.

A decision is taken whenever no grant is out. High-priority requests win over low-priority ones, and within a class the agents take turns. The owner keeps the bus for as long as it requests. When the bus is idle, the grant stays with the last owner if that owner may park. If it may not, the grant goes to the internal master. Detection counts the cycles in which a requesting owner holds the grant without ever asserting FRAME. When the count passes the programmed window, the grant is withdrawn and a sticky flag is set for that agent. While the flag is set, the agent's requests are ignored.

Top module: `pci_bus_arbiter`

## Requirements
- R1: While reset is low, no grant is asserted and the register reads 0. In the first cycle after reset is released no grant is asserted. From the cycle after that, the grant of agent 0 is asserted (parked).
- R2: At most one bit of `gnt_o` is set in any cycle.
- R3: When the grant moves from one agent to another, there is exactly one cycle with no grant asserted.
- R4: Register bit 31 enables arbitration. While the bit is 0, only agent 0 can be granted and requests from agents 1 to 6 are ignored.
- R5: Register bits 7+i (i = 0..6) set the priority class of agent i, with 1 meaning high. At a decision, any eligible high-priority request wins over every low-priority request.
- R6: Within one class, agents are served round-robin. The search starts at the agent after the one last picked in that class. After reset, the search in each class starts at agent 1.
- R7: An agent keeps its grant while its request stays asserted and it is not flagged broken, even if other agents request.
- R8: With no eligible request, the grant stays on the last owner when its park-disable bit is 0 (register bits 14+i), the agent is not broken, and it is agent 0 or arbitration is enabled. Otherwise the grant moves to agent 0.
- R9: Bit 1 enables broken detection and bits [6:3] hold the window W. An owner that requests, has not asserted FRAME since it was granted, and has held the grant for W+1 such cycles loses the grant at the end of the last of those cycles. In the same cycle its broken flag (register bit 21+i) sets.
- R10: A set broken flag makes the arbiter ignore that agent's requests, and the agent is never parked on unless it is agent 0. Writing 1 to bit 21+i clears the flag. Writing 0 leaves the flag unchanged. A flag set in the same cycle as a write that clears another agent's flag is kept.
- R11: A register write stores bits 31, 20:7, 6:3 and 1. A read returns those bits together with the broken flags in bits 27:21. Bits 30:28, 2 and 0 read 0. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 7 | Request per agent, bit 0 is the internal master |
| frame_i | input | 1 | High when the bus owner has started a transaction |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read data, including broken flags |
| gnt_o | output | 7 | Grant per agent, one-hot or zero |

## Verification
Two updates can reach the broken-flag vector in the same edge: a timeout of the current owner sets its flag, and a software write clears another agent's flag. The bench sets up this case directly. It lets agent 4 be flagged, grants agent 2 with FRAME held low, and issues the clearing write for agent 4 in exactly the third granted cycle of agent 2 under a window of 2. The readback is then judged: agent 2's flag must be set and agent 4's flag must be clear. Random traffic with random register writes also hits the same case, and a cycle model in the bench checks every grant and every readback.

// File: rtl/pci_arb_pkg.sv
// Shared constants and the control register view for the bus arbiter.
// Assumes agent 0 is the internal master; bit positions follow from AGENTS.
package pci_arb_pkg;
    localparam int AGENTS   = 7;
    localparam int IDX_W    = $clog2(AGENTS);
    localparam int WIN_W    = 4;
    localparam int REG_W    = 32;
    localparam int DET_BIT  = 1;
    localparam int WIN_LSB  = 3;
    localparam int PRIO_LSB = WIN_LSB + WIN_W;
    localparam int PARK_LSB = PRIO_LSB + AGENTS;
    localparam int BRK_LSB  = PARK_LSB + AGENTS;
    localparam int RUN_BIT  = REG_W - 1;

    typedef struct packed {
        logic              run;
        logic [AGENTS-1:0] park_dis;
        logic [AGENTS-1:0] prio;
        logic [WIN_W-1:0]  win;
        logic              det_en;
    } ctrl_t;
endpackage

// File: rtl/pci_arb_ctrl_reg.sv
// Control register and sticky broken flags.
// Writes land on the next edge; flags clear on write-1 and set on brk_set, set wins.
module pci_arb_ctrl_reg
    import pci_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    input  logic [AGENTS-1:0] brk_set,
    output ctrl_t             ctrl,
    output logic [AGENTS-1:0] brk,
    output logic [REG_W-1:0]  rdata
);
    logic [AGENTS-1:0] brk_clr;
    logic              unused_wbits;

    assign brk_clr      = wr_en ? wdata[BRK_LSB +: AGENTS] : {AGENTS{1'b0}};
    assign unused_wbits = ^{wdata[RUN_BIT-1:BRK_LSB+AGENTS], wdata[DET_BIT+1], wdata[0]};

    // Store writable fields and keep the broken flags sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            brk  <= '0;
        end else begin
            if (wr_en) begin
                ctrl.run      <= wdata[RUN_BIT];
                ctrl.park_dis <= wdata[PARK_LSB +: AGENTS];
                ctrl.prio     <= wdata[PRIO_LSB +: AGENTS];
                ctrl.win      <= wdata[WIN_LSB +: WIN_W];
                ctrl.det_en   <= wdata[DET_BIT];
            end
            brk <= (brk & ~brk_clr) | brk_set;
        end
    end

    // Assemble the read view; unused positions stay zero.
    always_comb begin
        rdata                      = '0;
        rdata[RUN_BIT]             = ctrl.run;
        rdata[BRK_LSB +: AGENTS]   = brk;
        rdata[PARK_LSB +: AGENTS]  = ctrl.park_dis;
        rdata[PRIO_LSB +: AGENTS]  = ctrl.prio;
        rdata[WIN_LSB +: WIN_W]    = ctrl.win;
        rdata[DET_BIT]             = ctrl.det_en;
    end
endmodule

// File: rtl/pci_arb_rr_pick.sv
// Round-robin picker: first set bit of vec searching upward from ptr+1, wrapping.
// Assumes ptr < N.
module pci_arb_rr_pick #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from farthest to nearest so the nearest candidate is kept last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N; k >= 1; k--) begin
            if (vec[(int'(ptr) + k) % N]) begin
                found = 1'b1;
                idx   = IW'((int'(ptr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/pci_arb_tenure_mon.sv
// Watches one grant tenure for a master that requests but never starts FRAME.
// start restarts the tenure; hit fires when the idle count has reached the window.
module pci_arb_tenure_mon #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          active,
    input  logic          req_own,
    input  logic          frame,
    input  logic          det_en,
    input  logic [WW-1:0] win,
    output logic          hit
);
    logic [WW-1:0] cnt;
    logic          seen;
    logic          stall;

    assign stall = active && det_en && req_own && !frame && !seen;
    assign hit   = stall && (cnt >= win);

    // Count stalled grant cycles and remember whether FRAME came.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (active) begin
            if (frame) seen <= 1'b1;
            if (stall && (cnt < win)) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pci_bus_arbiter.sv
// Seven-agent bus arbiter: two priority classes with round-robin in each,
// non-preemptive ownership, park-on-last with fallback to agent 0, and
// broken-master removal. A grant is only issued from a cycle with no grant,
// so every hand-over carries one idle cycle.
module pci_bus_arbiter
    import pci_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AGENTS-1:0] req_i,
    input  logic              frame_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [AGENTS-1:0] gnt_o
);
    ctrl_t             ctrl;
    logic [AGENTS-1:0] brk, brk_set, elig, agent_mask;
    logic [IDX_W-1:0]  own_q, last_q, park_idx, tgt, win_idx;
    logic              own_vld_q, any_req, park_ok, keep, hit;
    logic [AGENTS-1:0] cls_vec   [2];
    logic              cls_found [2];
    logic [IDX_W-1:0]  cls_idx   [2];
    logic [IDX_W-1:0]  ptr_q     [2];

    pci_arb_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .wdata(reg_wdata_i),
        .brk_set(brk_set), .ctrl(ctrl), .brk(brk), .rdata(reg_rdata_o)
    );

    // Eligible requests: not broken, and only agent 0 while arbitration is off.
    always_comb begin
        agent_mask = ctrl.run ? {AGENTS{1'b1}} : AGENTS'(1);
        elig       = req_i & ~brk & agent_mask;
        cls_vec[1] = elig & ctrl.prio;
        cls_vec[0] = elig & ~ctrl.prio;
    end

    // One round-robin picker per priority class (1 = high, 0 = low).
    for (genvar c = 0; c < 2; c++) begin : g_cls
        pci_arb_rr_pick #(.N(AGENTS), .IW(IDX_W)) u_pick (
            .vec(cls_vec[c]), .ptr(ptr_q[c]), .found(cls_found[c]), .idx(cls_idx[c])
        );
    end

    // Choose the next owner and decide whether the present one stays.
    always_comb begin
        any_req  = |elig;
        win_idx  = cls_found[1] ? cls_idx[1] : cls_idx[0];
        park_ok  = !ctrl.park_dis[last_q] && !brk[last_q] && ((last_q == '0) || ctrl.run);
        park_idx = park_ok ? last_q : '0;
        tgt      = any_req ? win_idx : park_idx;
        keep     = own_vld_q && !hit && (elig[own_q] || (!any_req && (park_idx == own_q)));
    end

    pci_arb_tenure_mon #(.WW(WIN_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .start(!own_vld_q), .active(own_vld_q),
        .req_own(elig[own_q]), .frame(frame_i), .det_en(ctrl.det_en),
        .win(ctrl.win), .hit(hit)
    );

    assign brk_set = hit ? (AGENTS'(1) << own_q) : {AGENTS{1'b0}};
    assign gnt_o   = own_vld_q ? (AGENTS'(1) << own_q) : {AGENTS{1'b0}};

    // Ownership: drop to idle on loss, grant from idle, advance class pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q     <= '0;
            last_q    <= '0;
            own_vld_q <= 1'b0;
            ptr_q[0]  <= '0;
            ptr_q[1]  <= '0;
        end else if (own_vld_q) begin
            if (!keep) own_vld_q <= 1'b0;
        end else begin
            own_q     <= tgt;
            last_q    <= tgt;
            own_vld_q <= 1'b1;
            if (any_req) begin
                if (cls_found[1]) ptr_q[1] <= cls_idx[1];
                else              ptr_q[0] <= cls_idx[0];
            end
        end
    end
endmodule

// File: rtl/pci_arb_checks.sv
// Port-level properties of the bus arbiter, bound into every instance.
// Reads control and broken state only through the register read port.
module pci_arb_checks
    import pci_arb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [AGENTS-1:0] gnt_o,
    input logic [REG_W-1:0]  reg_rdata_o
);
    logic unused_rbits;
    assign unused_rbits = ^{reg_rdata_o[PARK_LSB+AGENTS-1:DET_BIT]};

    AST_ONE_GNT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o)) else $error("more than one grant"); // R2
    AST_GAP_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n) (gnt_o != '0) |=> ((gnt_o == '0) || (gnt_o == $past(gnt_o)))) else $error("grant moved without idle cycle"); // R3
    AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !$past(reg_rdata_o[RUN_BIT]) |-> (gnt_o[AGENTS-1:1] == '0)) else $error("external grant while disabled"); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata_o[RUN_BIT-1:BRK_LSB+AGENTS] == '0) && !reg_rdata_o[DET_BIT+1] && !reg_rdata_o[0]) else $error("reserved bits set"); // R11

    for (genvar i = 0; i < AGENTS; i++) begin : g_agt
        AST_BRK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) $rose(reg_rdata_o[BRK_LSB+i]) |-> !gnt_o[i]) else $error("broken agent kept grant"); // R9
        if (i > 0) begin : g_ext
            AST_BRK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) $past(reg_rdata_o[BRK_LSB+i]) |-> !gnt_o[i]) else $error("broken agent granted"); // R10
        end
    end
endmodule

bind pci_bus_arbiter pci_arb_checks u_checks (
    .clk(clk), .rst_n(rst_n), .gnt_o(gnt_o), .reg_rdata_o(reg_rdata_o)
);

// File: tb/sim_pci_bus_arbiter.sv
`timescale 1ns/1ps
module sim_pci_bus_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req = '0;
    logic        frame = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  gnt;

    always #4 clk = ~clk;

    pci_bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .frame_i(frame),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gnt_o(gnt)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    // Bench model state, written from the requirements.
    logic [31:0] m_reg;
    logic [6:0]  m_brk;
    int          m_own, m_last, m_phi, m_plo, m_cnt;
    bit          m_vld, m_seen;

    function automatic logic [6:0] m_gnt();
        return m_vld ? 7'(1 << m_own) : 7'h0;
    endfunction

    function automatic logic [31:0] m_rd();
        return m_reg | ({25'h0, m_brk} << 21);
    endfunction

    function automatic int rr(input logic [6:0] v, input int p, output bit f);
        f = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            int j;
            j = (p + k) % 7;
            if (v[j]) begin
                f = 1'b1;
                return j;
            end
        end
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_reg = '0; m_brk = '0; m_own = 0; m_last = 0; m_phi = 0; m_plo = 0;
        m_cnt = 0; m_vld = 1'b0; m_seen = 1'b0;
    endtask

    // One clock edge of the model with the inputs of that cycle.
    task automatic m_step(input logic [6:0] r, input bit f, input bit w, input logic [31:0] wd);
        bit run, det, any, hf, lf, pok, hit, keep;
        logic [6:0] prio, pd, elig;
        int win, hi, li, widx, pidx, tgt;
        run  = m_reg[31]; det = m_reg[1]; prio = m_reg[13:7]; pd = m_reg[20:14];
        win  = int'(m_reg[6:3]);
        elig = r & ~m_brk & (run ? 7'h7f : 7'h01);
        hi   = rr(elig & prio, m_phi, hf);
        li   = rr(elig & ~prio, m_plo, lf);
        any  = |elig;
        widx = hf ? hi : li;
        pok  = !pd[m_last] && !m_brk[m_last] && (m_last == 0 || run);
        pidx = pok ? m_last : 0;
        tgt  = any ? widx : pidx;
        hit  = m_vld && det && elig[m_own] && !f && !m_seen && (m_cnt >= win);
        keep = m_vld && !hit && (elig[m_own] || (!any && pidx == m_own));
        m_brk = (m_brk & ~(w ? wd[27:21] : 7'h0)) | (hit ? 7'(1 << m_own) : 7'h0);
        if (w) m_reg = wd & 32'h801F_FFFA;
        if (!m_vld) begin
            m_cnt = 0; m_seen = 1'b0;
        end else begin
            if (det && elig[m_own] && !f && !m_seen && m_cnt < win) m_cnt++;
            if (f) m_seen = 1'b1;
        end
        if (m_vld) begin
            if (!keep) m_vld = 1'b0;
        end else begin
            m_own = tgt; m_vld = 1'b1; m_last = tgt;
            if (any) begin
                if (hf) m_phi = hi;
                else    m_plo = li;
            end
        end
    endtask

    // Drive one cycle of inputs, advance the model, and check at the next negedge.
    task automatic cyc(input logic [6:0] r, input bit f, input bit w, input logic [31:0] wd);
        req = r; frame = f; wr = w; wdata = wd;
        m_step(r, f, w, wd);
        @(negedge clk);
        wr = 1'b0;
        chk(gnt == m_gnt(), "R7 grant vs model", {25'h0, gnt}, {25'h0, m_gnt()});
        chk(rdata == m_rd(), "R11 readback vs model", rdata, m_rd());
        chk($onehot0(gnt), "R2 single grant", {25'h0, gnt}, 32'h0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int n_ev, seen_cnt, prev;
        logic [6:0] rq;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        chk(gnt == 7'h0, "R1 no grant in reset", {25'h0, gnt}, 32'h0);
        chk(rdata == 32'h0, "R1 register in reset", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        m_step(7'h0, 1'b0, 1'b0, 32'h0);
        chk(gnt == 7'h01, "R1 parked on agent 0 after reset", {25'h0, gnt}, 32'h1);

        // R11: register layout
        cyc(7'h0, 0, 1, 32'hFFFF_FFFF);
        chk(rdata == 32'h801F_FFFA, "R11 writable bits", rdata, 32'h801F_FFFA);
        cyc(7'h0, 0, 1, 32'h0);
        chk(rdata == 32'h0, "R11 cleared", rdata, 32'h0);

        // R4: external requests ignored while arbitration is off
        for (int i = 0; i < 4; i++) begin
            cyc(7'b0001000, 0, 0, 0);
            chk(gnt == 7'h01, "R4 external ignored when off", {25'h0, gnt}, 32'h1);
        end

        // R3, R7: hand-over gap, then no preemption
        cyc(7'h0, 0, 1, 32'h8000_0000);
        cyc(7'b0001000, 0, 0, 0);
        chk(gnt == 7'h0, "R3 idle cycle on hand-over", {25'h0, gnt}, 32'h0);
        cyc(7'b0001000, 0, 0, 0);
        chk(gnt == 7'b0001000, "R3 new owner granted", {25'h0, gnt}, 32'h8);
        for (int i = 0; i < 3; i++) begin
            cyc(7'b0001010, 0, 0, 0);
            chk(gnt == 7'b0001000, "R7 owner not preempted", {25'h0, gnt}, 32'h8);
        end

        // R8: park on last, then park-disable falls back to agent 0
        for (int i = 0; i < 2; i++) begin
            cyc(7'h0, 0, 0, 0);
            chk(gnt == 7'b0001000, "R8 parked on last owner", {25'h0, gnt}, 32'h8);
        end
        cyc(7'h0, 0, 1, 32'h8000_0000 | (32'h1 << 17));
        cyc(7'h0, 0, 0, 0);
        chk(gnt == 7'h0, "R8 leaves disabled parker", {25'h0, gnt}, 32'h0);
        cyc(7'h0, 0, 0, 0);
        chk(gnt == 7'h01, "R8 falls back to agent 0", {25'h0, gnt}, 32'h1);

        // R5: high-priority agent 5 wins over agent 2
        cyc(7'h0, 0, 1, 32'h8002_0000 | (32'h1 << 12));
        cyc(7'b0100100, 0, 0, 0);
        cyc(7'b0100100, 0, 0, 0);
        chk(gnt == 7'b0100000, "R5 high class wins", {25'h0, gnt}, 32'h20);

        // R6: agents 1 and 2 alternate when each drops after its grant
        cyc(7'h0, 0, 1, 32'h8000_0000);
        rq = 7'b0000110; n_ev = 0; prev = -1;
        for (int i = 0; i < 60; i++) begin
            logic [6:0] g_before;
            g_before = gnt;
            cyc(rq, 0, 0, 0);
            if (gnt != 7'h0 && gnt != g_before && (gnt & 7'b0000110) != 7'h0) begin
                if (prev >= 0) chk(gnt != 7'(prev), "R6 round-robin alternation", {25'h0, gnt}, 32'(prev));
                prev = int'(gnt); n_ev++;
            end
            rq = (gnt != 7'h0) ? (7'b0000110 & ~gnt) : 7'b0000110;
        end
        chk(n_ev >= 4, "R6 enough rotations", 32'(n_ev), 32'd4);

        // R9: agent 4 stalls with window 2, holds grant 3 cycles
        cyc(7'h0, 0, 1, 32'h8000_0012);
        seen_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(7'b0010000, 0, 0, 0);
            if (gnt[4]) seen_cnt++;
        end
        chk(seen_cnt == 3, "R9 grant held W+1 cycles", 32'(seen_cnt), 32'd3);
        chk(rdata[25] == 1'b1, "R9 broken flag set", {31'h0, rdata[25]}, 32'h1);
        for (int i = 0; i < 5; i++) begin
            cyc(7'b0010000, 0, 0, 0);
            chk(gnt[4] == 1'b0, "R10 broken agent ignored", {25'h0, gnt}, 32'h0);
        end

        // R9: FRAME in the tenure prevents detection
        seen_cnt = 0;
        for (int i = 0; i < 14; i++) begin
            cyc(7'b1000000, (gnt[6] && seen_cnt == 1), 0, 0);
            if (gnt[6]) seen_cnt++;
        end
        chk(seen_cnt >= 10, "R9 FRAME keeps grant", 32'(seen_cnt), 32'd10);
        chk(rdata[27] == 1'b0, "R9 no flag after FRAME", {31'h0, rdata[27]}, 32'h0);

        // R10: timeout of agent 2 in the same edge as clearing agent 4
        seen_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            if (seen_cnt == 3) begin
                cyc(7'b0000100, 0, 1, 32'h8000_0012 | (32'h1 << 25));
                seen_cnt = 99;
                chk(rdata[25] == 1'b0, "R10 write-1 clears flag", {31'h0, rdata[25]}, 32'h0);
                chk(rdata[23] == 1'b1, "R10 same-cycle set kept", {31'h0, rdata[23]}, 32'h1);
            end else begin
                cyc(7'b0000100, 0, 0, 0);
                if (gnt[2] && seen_cnt < 99) seen_cnt++;
            end
        end
        seen_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(7'b0010000, 0, 0, 0);
            if (gnt[4]) seen_cnt++;
        end
        chk(seen_cnt > 0, "R10 cleared agent served again", 32'(seen_cnt), 32'd1);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            bit          w;
            w  = ($urandom % 25) == 0;
            wd = $urandom;
            wd[31] = ($urandom % 8) != 0;
            cyc(7'($urandom & $urandom), ($urandom % 4) == 0, w, wd);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule